// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block predicts the direction and target of direct branches for an instruction fetch unit. The fetch stage presents a program counter each cycle. In the same cycle it gets back whether the buffer holds that address, the predicted direction and the stored target. The buffer is direct-mapped. Each slot holds a valid flag, an address tag, a target and a 2-bit saturating history counter.

The execute stage reports every resolved control transfer on the update side: its address, its class, the instruction-set mode it ran in, whether it was taken and its real target. In the same cycle the block says whether the earlier prediction was wrong and how many extra cycles that costs. At the clock edge it then writes the buffer state. Only plain direct branches, and branch-with-link in the wide 32-bit mode, are tracked. Any other write to the program counter always counts as predicted not-taken and never enters the buffer.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) invalidates every slot, so after it every fetch lookup reports no hit and not-taken.
- R2: Updates with `updClass` 2 (other PC write) or 3 (reserved), and class 1 (branch-with-link) when `updCompact` is 1, are predicted not-taken, flag a misprediction exactly when taken, and never write the buffer, even when a slot matches their address.
- R3: An eligible branch (class 0 in either mode, or class 1 with `updCompact` 0) that misses the buffer is written into it only when it resolves taken; a not-taken miss leaves the buffer unchanged.
- R4: A fetch address that misses the buffer is predicted not-taken.
- R5: A newly written slot starts at counter value 2 (weakly taken), so the next fetch of that address reports a hit, taken, with the resolved target.
- R6: On a hit, the counter of an eligible branch rises by one when taken and falls by one when not taken, saturating at 3 and at 0; the fetch prediction is taken exactly when the counter's upper bit is 1.
- R7: `updMispredict` is 1 for an update only when the branch was a hit predicted not-taken but taken, a miss that was taken, or a hit predicted taken but not taken; otherwise it is 0.
- R8: `updPenalty` is 0 for a correct prediction, 4 for a misprediction with `updCompact` 0, and 5 for a misprediction with `updCompact` 1, valid in the cycle `updValid` is high.
- R9: An eligible taken branch whose slot (address bits 7:1) holds a different tag replaces that slot, so the former occupant then misses.
- R10: A fetch lookup in the same cycle as an update to the same slot sees the slot contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchPc | input | 32 | Address being fetched |
| fetchHit | output | 1 | Address found in the buffer |
| fetchTaken | output | 1 | Predicted direction, 1 = taken |
| fetchTarget | output | 32 | Predicted target (meaningful on hit) |
| updValid | input | 1 | Resolved-branch update strobe |
| updPc | input | 32 | Address of the resolved instruction |
| updClass | input | 2 | 0 direct branch, 1 branch-with-link, 2 other PC write, 3 reserved |
| updCompact | input | 1 | 1 = 16-bit instruction mode, 0 = 32-bit mode |
| updTaken | input | 1 | Actual outcome |
| updTarget | input | 32 | Actual target |
| updMispredict | output | 1 | Prediction was wrong |
| updPenalty | output | 3 | Extra cycles caused by this branch |

## Verification
Saturation of the counter at both ends is the hardest state to reach from the ports. No counter value is visible, so the bench drives one address through long runs of same-direction outcomes. It then infers the count from how many opposite outcomes it takes before the predicted direction flips. A second case is a non-eligible write to an address that the buffer already predicts taken. The bench first trains that address, then sends the other class, then fetches it again to show the slot is untouched.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    CLS_B    = 2'd0,
    CLS_BL   = 2'd1,
    CLS_PCWR = 2'd2,
    CLS_RSVD = 2'd3
  } brClass_e;

  typedef struct packed {
    logic       allocStb;
    logic       ctrWrStb;
    logic       tgtWrStb;
    logic [1:0] newCtr;
  } btbWr_t;

  localparam logic [1:0] CTR_WEAK_TAKEN = 2'b10;
endpackage

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 128,
  parameter int ALIGN   = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetchPc,
  output logic            fetchHit,
  output logic            fetchTaken,
  output logic [PC_W-1:0] fetchTarget,
  input  logic [PC_W-1:0] updPc,
  output logic            updHit,
  output logic [1:0]      updCtr,
  input  btbWr_t          wr,
  input  logic [PC_W-1:0] wrTarget
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_LSB = ALIGN + IDX_W;
  localparam int TAG_W = PC_W - TAG_LSB;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ [ENTRIES];
  logic [PC_W-1:0]    tgtQ [ENTRIES];
  logic [1:0]         ctrQ [ENTRIES];

  logic [IDX_W-1:0] fIdx, uIdx;
  logic [TAG_W-1:0] fTag, uTag;

  assign fIdx = fetchPc[TAG_LSB-1:ALIGN];
  assign fTag = fetchPc[PC_W-1:TAG_LSB];
  assign uIdx = updPc[TAG_LSB-1:ALIGN];
  assign uTag = updPc[PC_W-1:TAG_LSB];

  assign fetchHit    = validQ[fIdx] && (tagQ[fIdx] == fTag);
  assign fetchTaken  = fetchHit && ctrQ[fIdx][1];
  assign fetchTarget = tgtQ[fIdx];
  assign updHit      = validQ[uIdx] && (tagQ[uIdx] == uTag);
  assign updCtr      = ctrQ[uIdx];

  always_ff @(posedge clk) begin
    if (rst) validQ <= '0;
    else if (wr.allocStb) validQ[uIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      if (wr.allocStb) tagQ[uIdx] <= uTag;
      if (wr.allocStb || wr.tgtWrStb) tgtQ[uIdx] <= wrTarget;
      if (wr.allocStb || wr.ctrWrStb) ctrQ[uIdx] <= wr.newCtr;
    end
  end

  // Assertions
  p_miss_not_taken_r4: assert property (@(posedge clk) disable iff (rst)
    !fetchHit |-> !fetchTaken);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> !fetchHit && !updHit);
  p_alloc_valid_r5: assert property (@(posedge clk) disable iff (rst)
    wr.allocStb |=> validQ[$past(uIdx)] && ctrQ[$past(uIdx)] == CTR_WEAK_TAKEN);
  p_alloc_single_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr.allocStb && wr.ctrWrStb));
endmodule

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
#(
  parameter int PEN_W       = 3,
  parameter int PEN_WIDE    = 4,
  parameter int PEN_COMPACT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             updValid,
  input  brClass_e         updClass,
  input  logic             updCompact,
  input  logic             updTaken,
  input  logic             updHit,
  input  logic [1:0]       updCtr,
  output btbWr_t           wr,
  output logic             updMispredict,
  output logic [PEN_W-1:0] updPenalty
);
  logic eligible, hitE, predTaken;
  logic [1:0] nextCtr;

  always_comb begin
    eligible  = (updClass == CLS_B) || (updClass == CLS_BL && !updCompact);
    hitE      = eligible && updHit;
    predTaken = hitE && updCtr[1];
    if (!hitE)         nextCtr = CTR_WEAK_TAKEN;
    else if (updTaken) nextCtr = (updCtr == 2'b11) ? 2'b11 : updCtr + 2'b01;
    else               nextCtr = (updCtr == 2'b00) ? 2'b00 : updCtr - 2'b01;
  end

  always_comb begin
    wr.allocStb   = updValid && eligible && !updHit && updTaken;
    wr.ctrWrStb   = updValid && hitE;
    wr.tgtWrStb   = updValid && hitE && updTaken;
    wr.newCtr     = nextCtr;
    updMispredict = updValid && (predTaken != updTaken);
    if (!updMispredict)  updPenalty = '0;
    else if (updCompact) updPenalty = PEN_W'(PEN_COMPACT);
    else                 updPenalty = PEN_W'(PEN_WIDE);
  end

  // Assertions
  p_penalty_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (updValid && !updMispredict) |-> updPenalty == '0);
  p_penalty_mode_r8: assert property (@(posedge clk) disable iff (rst)
    updMispredict |-> updPenalty == (updCompact ? PEN_W'(PEN_COMPACT) : PEN_W'(PEN_WIDE)));
  p_ineligible_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    (updClass == CLS_PCWR || updClass == CLS_RSVD) |-> !(wr.allocStb || wr.ctrWrStb));
  p_miss_taken_mispredicts_r7: assert property (@(posedge clk) disable iff (rst)
    (updValid && !updHit && updTaken) |-> updMispredict);
  p_sat_top_r6: assert property (@(posedge clk) disable iff (rst)
    (wr.ctrWrStb && updCtr == 2'b11 && updTaken) |-> wr.newCtr == 2'b11);
  p_sat_bottom_r6: assert property (@(posedge clk) disable iff (rst)
    (wr.ctrWrStb && updCtr == 2'b00 && !updTaken) |-> wr.newCtr == 2'b00);
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int ENTRIES     = 128,
  parameter int ALIGN       = 1,
  parameter int PEN_W       = 3,
  parameter int PEN_WIDE    = 4,
  parameter int PEN_COMPACT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  fetchPc,
  output logic             fetchHit,
  output logic             fetchTaken,
  output logic [PC_W-1:0]  fetchTarget,
  input  logic             updValid,
  input  logic [PC_W-1:0]  updPc,
  input  logic [1:0]       updClass,
  input  logic             updCompact,
  input  logic             updTaken,
  input  logic [PC_W-1:0]  updTarget,
  output logic             updMispredict,
  output logic [PEN_W-1:0] updPenalty
);
  btbWr_t     wrStb;
  logic       updHit;
  logic [1:0] updCtr;

  btb_datapath #(.PC_W(PC_W), .ENTRIES(ENTRIES), .ALIGN(ALIGN)) dp_i (
    .clk(clk), .rst(rst),
    .fetchPc(fetchPc), .fetchHit(fetchHit), .fetchTaken(fetchTaken),
    .fetchTarget(fetchTarget),
    .updPc(updPc), .updHit(updHit), .updCtr(updCtr),
    .wr(wrStb), .wrTarget(updTarget)
  );

  btb_ctrl #(.PEN_W(PEN_W), .PEN_WIDE(PEN_WIDE), .PEN_COMPACT(PEN_COMPACT)) ctrl_i (
    .clk(clk), .rst(rst),
    .updValid(updValid), .updClass(brClass_e'(updClass)),
    .updCompact(updCompact), .updTaken(updTaken),
    .updHit(updHit), .updCtr(updCtr),
    .wr(wrStb), .updMispredict(updMispredict), .updPenalty(updPenalty)
  );
endmodule

// File: tb/btb_predictor_tb.sv
module btb_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetchPc = '0;
  logic        fetchHit, fetchTaken;
  logic [31:0] fetchTarget;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic [1:0]  updClass = 2'd0;
  logic        updCompact = 1'b0;
  logic        updTaken = 1'b0;
  logic [31:0] updTarget = '0;
  logic        updMispredict;
  logic [2:0]  updPenalty;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  btb_predictor dut_i (
    .clk(clk), .rst(rst), .fetchPc(fetchPc), .fetchHit(fetchHit),
    .fetchTaken(fetchTaken), .fetchTarget(fetchTarget),
    .updValid(updValid), .updPc(updPc), .updClass(updClass),
    .updCompact(updCompact), .updTaken(updTaken), .updTarget(updTarget),
    .updMispredict(updMispredict), .updPenalty(updPenalty)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // drive one update, check same-cycle outputs, commit at the next edge
  task automatic upd(input string req, input logic [31:0] pc, input logic [1:0] cls,
                     input logic cmp, input logic tk, input logic [31:0] tgt,
                     input logic expMis, input logic [2:0] expPen);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updClass = cls; updCompact = cmp;
    updTaken = tk; updTarget = tgt;
    #1;
    check(req, "mispredict", {31'b0, updMispredict}, {31'b0, expMis});
    check(req, "penalty", {29'b0, updPenalty}, {29'b0, expPen});
    @(posedge clk); #1;
    updValid = 1'b0;
  endtask

  task automatic look(input string req, input logic [31:0] pc, input logic expHit,
                      input logic expTk, input logic [31:0] expTgt, input logic chkTgt);
    @(negedge clk);
    fetchPc = pc; #1;
    check(req, "fetchHit", {31'b0, fetchHit}, {31'b0, expHit});
    check(req, "fetchTaken", {31'b0, fetchTaken}, {31'b0, expTk});
    if (chkTgt) check(req, "fetchTarget", fetchTarget, expTgt);
  endtask

  localparam logic [31:0] PC_A = 32'h0000_1010;
  localparam logic [31:0] PC_G = PC_A + 32'd256; // same slot, other tag
  localparam logic [31:0] T_A  = 32'h0000_4000;

  task automatic tReset();
    look("R1", PC_A, 1'b0, 1'b0, 0, 1'b0);
    look("R1", 32'h0, 1'b0, 1'b0, 0, 1'b0);
  endtask

  task automatic tMissNotTaken();
    upd("R3", PC_A, 2'd0, 1'b0, 1'b0, T_A, 1'b0, 3'd0);
    look("R3", PC_A, 1'b0, 1'b0, 0, 1'b0);
    look("R4", PC_A + 32'h20, 1'b0, 1'b0, 0, 1'b0);
  endtask

  task automatic tFirstTaken();
    upd("R7", PC_A, 2'd0, 1'b0, 1'b1, T_A, 1'b1, 3'd4);
    look("R5", PC_A, 1'b1, 1'b1, T_A, 1'b1);
  endtask

  task automatic tCounter();
    // ctr 2 -> 3 -> 3 (saturate)
    upd("R6", PC_A, 2'd0, 1'b0, 1'b1, T_A, 1'b0, 3'd0);
    upd("R6", PC_A, 2'd0, 1'b0, 1'b1, T_A, 1'b0, 3'd0);
    // 3 -> 2 (predicted taken, wrong), 2 -> 1 (still predicted taken)
    upd("R7", PC_A, 2'd0, 1'b0, 1'b0, T_A, 1'b1, 3'd4);
    look("R6", PC_A, 1'b1, 1'b1, T_A, 1'b1);
    upd("R6", PC_A, 2'd0, 1'b0, 1'b0, T_A, 1'b1, 3'd4);
    look("R6", PC_A, 1'b1, 1'b0, T_A, 1'b1);
    // 1 -> 0 -> 0
    upd("R6", PC_A, 2'd0, 1'b0, 1'b0, T_A, 1'b0, 3'd0);
    upd("R6", PC_A, 2'd0, 1'b0, 1'b0, T_A, 1'b0, 3'd0);
    // 0 -> 1 (hit predicted not-taken but taken), 1 -> 2
    upd("R7", PC_A, 2'd0, 1'b0, 1'b1, T_A, 1'b1, 3'd4);
    look("R6", PC_A, 1'b1, 1'b0, T_A, 1'b1);
    upd("R6", PC_A, 2'd0, 1'b0, 1'b1, T_A, 1'b1, 3'd4);
    look("R6", PC_A, 1'b1, 1'b1, T_A, 1'b1);
  endtask

  task automatic tModes();
    upd("R8", 32'h0000_2002, 2'd0, 1'b1, 1'b1, 32'h2100, 1'b1, 3'd5);
    look("R3", 32'h0000_2002, 1'b1, 1'b1, 32'h2100, 1'b1);
    upd("R8", 32'h0000_2008, 2'd1, 1'b0, 1'b1, 32'h2200, 1'b1, 3'd4);
    look("R3", 32'h0000_2008, 1'b1, 1'b1, 32'h2200, 1'b1);
    upd("R2", 32'h0000_200C, 2'd1, 1'b1, 1'b1, 32'h2300, 1'b1, 3'd5);
    look("R2", 32'h0000_200C, 1'b0, 1'b0, 0, 1'b0);
  endtask

  task automatic tIneligible();
    upd("R2", 32'h0000_3000, 2'd2, 1'b0, 1'b1, 32'h3100, 1'b1, 3'd4);
    upd("R2", 32'h0000_3000, 2'd2, 1'b0, 1'b1, 32'h3100, 1'b1, 3'd4);
    look("R2", 32'h0000_3000, 1'b0, 1'b0, 0, 1'b0);
    upd("R2", 32'h0000_3004, 2'd3, 1'b0, 1'b0, 32'h3100, 1'b0, 3'd0);
    // other PC write at a trained address: no prediction, slot untouched
    upd("R2", PC_A, 2'd2, 1'b0, 1'b0, 32'h9999, 1'b0, 3'd0);
    upd("R2", PC_A, 2'd2, 1'b0, 1'b1, 32'h9999, 1'b1, 3'd4);
    look("R2", PC_A, 1'b1, 1'b1, T_A, 1'b1);
  endtask

  task automatic tConflict();
    upd("R9", PC_G, 2'd0, 1'b0, 1'b1, 32'h5000, 1'b1, 3'd4);
    look("R9", PC_A, 1'b0, 1'b0, 0, 1'b0);
    look("R9", PC_G, 1'b1, 1'b1, 32'h5000, 1'b1);
  endtask

  task automatic tSameCycle();
    @(negedge clk);
    fetchPc = 32'h0000_6006;
    updValid = 1'b1; updPc = 32'h0000_6006; updClass = 2'd0; updCompact = 1'b0;
    updTaken = 1'b1; updTarget = 32'h6100;
    #1;
    check("R10", "fetchHit same cycle", {31'b0, fetchHit}, 32'd0);
    @(posedge clk); #1;
    updValid = 1'b0; #1;
    check("R10", "fetchHit after", {31'b0, fetchHit}, 32'd1);
    check("R10", "fetchTarget after", fetchTarget, 32'h6100);
  endtask

  task automatic tResetAgain();
    doReset();
    look("R1", PC_G, 1'b0, 1'b0, 0, 1'b0);
    look("R1", 32'h0000_6006, 1'b0, 1'b0, 0, 1'b0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    tReset();
    tMissNotTaken();
    tFirstTaken();
    tCounter();
    tModes();
    tIneligible();
    tConflict();
    tSameCycle();
    tResetAgain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule